// File: doc/BRIEF.md
# Serial Port Data FIFO Pair

This block holds the two data queues that sit between a serial peripheral's shift logic and the system bus. The transmit queue takes frames from bus writes to the data register and hands them to the shifter. The receive queue takes frames from the shifter and returns them on bus reads of the same register. Each queue stores one frame per entry, right-justified in a 16-bit word. Frames can be 4 to 16 bits long.

Each side has a programmable threshold and a level flag. The transmit flag warns that the queue is nearly drained. The receive flag warns that the queue is nearly full, and its comparison is offset by one. The block also raises single-cycle error pulses in three cases: a write that was dropped because the transmit side was full, a shifted-in frame that was lost because the receive side was full, and a bus read of an empty receive side. Both queues are flushed by reset and for as long as the peripheral enable is low. Masking and clearing of these pulses, bus decoding and the serial shifter belong to neighbouring blocks.

Top module: `serial_fifo_pair`

## Requirements
- R1: After reset both counts read 0. On any clock edge where `enable` is 0, both queues are emptied, and every write, push and read request in that cycle is ignored and raises no error pulse.
- R2: A bus write (`busWrEn`) to a transmit queue that is not full stores the frame at the tail. `txCount` rises by one after that edge. `txPopData` shows the oldest stored frame while `txPopValid` is 1, and `txPopEn` removes it. A pop request on an empty transmit queue changes nothing.
- R3: A shifter push (`rxPushEn`) to a receive queue that is not full stores the frame at the tail, and `rxCount` rises by one. `busRdData` shows the oldest frame, and `busRdEn` removes it.
- R4: `txEmptyLvl` is 1 exactly when `txCount <= txThresh`. It follows the current count and threshold within the same cycle.
- R5: `rxFullLvl` is 1 exactly when `rxCount >= rxThresh + 1`. It follows the current count and threshold within the same cycle.
- R6: A bus write while `txCount` is 64 is discarded, even if a pop happens in the same cycle. `txOverflow` is 1 for exactly the one cycle after that edge.
- R7: A push while `rxCount` is 64 is dropped, even if a read happens in the same cycle. `rxOverrun` is 1 for exactly the one cycle after that edge.
- R8: A bus read while `rxCount` is 0 pops nothing. `rxUnderflow` is 1 for exactly the one cycle after that edge. While the receive queue is empty, `busRdData` reads 0. A push in the same cycle as such a read is still stored.
- R9: A push and a pop on the same side, with that side neither empty nor full, leave its count unchanged and keep first-in first-out order.
- R10: Each stored frame keeps its low `frameSize+1` bits, and the bits above read 0. A `frameSize` below 3 is treated as 3, which gives 4-bit frames. This applies to both queues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Peripheral enable; low flushes both queues |
| frameSize | input | 4 | Frame length minus one |
| txThresh | input | 6 | Transmit level threshold |
| rxThresh | input | 6 | Receive level threshold |
| busWrEn | input | 1 | Bus write to the data register |
| busWrData | input | 16 | Bus write frame |
| txPopEn | input | 1 | Shifter takes the oldest transmit frame |
| txPopData | output | 16 | Oldest transmit frame |
| txPopValid | output | 1 | Transmit queue holds at least one frame |
| rxPushEn | input | 1 | Shifter delivers a received frame |
| rxPushData | input | 16 | Received frame |
| busRdEn | input | 1 | Bus read of the data register |
| busRdData | output | 16 | Oldest receive frame, 0 when empty |
| txCount | output | 7 | Transmit entries, 0 to 64 |
| rxCount | output | 7 | Receive entries, 0 to 64 |
| txEmptyLvl | output | 1 | Transmit level flag |
| rxFullLvl | output | 1 | Receive level flag |
| txOverflow | output | 1 | Pulse: transmit write discarded |
| rxOverrun | output | 1 | Pulse: received frame lost |
| rxUnderflow | output | 1 | Pulse: read of empty receive queue |

## Verification
Counts, head data and error pulses are all due one edge after the request that causes them. Level flags and `busRdData` follow the counts and thresholds with no delay. The bench drives each request just after a rising edge and samples one time unit after the next rising edge, so each registered result is checked in its first valid cycle. Each error pulse is checked again one cycle later to confirm it has cleared. Threshold flags are swept over all 64 threshold values at every fill level from 0 to 64, with a short settle delay after each change and no clock edge needed.

// File: rtl/serial_fifo_pkg.sv
package serial_fifo_pkg;

  // Strobes from control to datapath, already qualified by enable and fullness.
  typedef struct packed {
    logic flush;
    logic txPush;
    logic txPop;
    logic rxPush;
    logic rxPop;
  } fifoStrobe_t;

  localparam int MIN_FRAME_BITS = 4;

endpackage

// File: rtl/serial_fifo_store.sv
module serial_fifo_store #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] head,
  output logic [CW-1:0]    count
);

  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr;
  logic [AW-1:0]    rdPtr;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head = mem[rdPtr];

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));

  a_r2_push_grows: assert property (@(posedge clk) disable iff (!rstN)
    (push && !pop && !flush) |=> count == CW'($past(count) + 1'b1));

  a_r9_push_pop_hold: assert property (@(posedge clk) disable iff (!rstN)
    (push && pop && !flush) |=> count == $past(count));

  a_r1_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> count == '0);

endmodule

// File: rtl/serial_fifo_data.sv
module serial_fifo_data
  import serial_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int WIDTH = 16,
  localparam int CW   = $clog2(DEPTH) + 1,
  localparam int FW   = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoStrobe_t      strb,
  input  logic [FW-1:0]    frameSize,
  input  logic [WIDTH-1:0] busWrData,
  input  logic [WIDTH-1:0] rxPushData,
  output logic [WIDTH-1:0] txPopData,
  output logic [WIDTH-1:0] busRdData,
  output logic [CW-1:0]    txCount,
  output logic [CW-1:0]    rxCount
);

  localparam logic [FW-1:0] MIN_SIZE = FW'(MIN_FRAME_BITS - 1);

  logic [FW-1:0]    effSize;
  logic [WIDTH-1:0] frameMask;
  logic [WIDTH-1:0] sideIn   [2];
  logic [WIDTH-1:0] sideHead [2];
  logic [CW-1:0]    sideCnt  [2];
  logic             sidePush [2];
  logic             sidePop  [2];

  assign effSize = (frameSize < MIN_SIZE) ? MIN_SIZE : frameSize;

  always_comb begin
    for (int b = 0; b < WIDTH; b++) begin
      frameMask[b] = (FW'(b) <= effSize);
    end
  end

  // Side 0 is transmit, side 1 is receive.
  assign sideIn[0]   = busWrData  & frameMask;
  assign sideIn[1]   = rxPushData & frameMask;
  assign sidePush[0] = strb.txPush;
  assign sidePop[0]  = strb.txPop;
  assign sidePush[1] = strb.rxPush;
  assign sidePop[1]  = strb.rxPop;

  for (genvar s = 0; s < 2; s++) begin : g_side
    serial_fifo_store #(
      .DEPTH (DEPTH),
      .WIDTH (WIDTH)
    ) store_i (
      .clk    (clk),
      .rstN   (rstN),
      .flush  (strb.flush),
      .push   (sidePush[s]),
      .pop    (sidePop[s]),
      .wrData (sideIn[s]),
      .head   (sideHead[s]),
      .count  (sideCnt[s])
    );
  end

  assign txCount   = sideCnt[0];
  assign rxCount   = sideCnt[1];
  assign txPopData = sideHead[0];
  assign busRdData = (sideCnt[1] == '0) ? '0 : sideHead[1];

endmodule

// File: rtl/serial_fifo_ctrl.sv
module serial_fifo_ctrl
  import serial_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int TW   = $clog2(DEPTH),
  localparam int CW   = TW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enable,
  input  logic          busWrEn,
  input  logic          txPopEn,
  input  logic          rxPushEn,
  input  logic          busRdEn,
  input  logic [CW-1:0] txCount,
  input  logic [CW-1:0] rxCount,
  input  logic [TW-1:0] txThresh,
  input  logic [TW-1:0] rxThresh,
  output fifoStrobe_t   strb,
  output logic          txPopValid,
  output logic          txEmptyLvl,
  output logic          rxFullLvl,
  output logic          txOverflow,
  output logic          rxOverrun,
  output logic          rxUnderflow
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic txFull, txEmpty, rxFull, rxEmpty;
  logic [CW-1:0] rxTrip;

  assign txFull  = (txCount == FULL_CNT);
  assign txEmpty = (txCount == '0);
  assign rxFull  = (rxCount == FULL_CNT);
  assign rxEmpty = (rxCount == '0);

  always_comb begin
    strb        = '0;
    strb.flush  = !enable;
    strb.txPush = enable && busWrEn  && !txFull;
    strb.txPop  = enable && txPopEn  && !txEmpty;
    strb.rxPush = enable && rxPushEn && !rxFull;
    strb.rxPop  = enable && busRdEn  && !rxEmpty;
  end

  assign txPopValid = !txEmpty;
  assign rxTrip     = {1'b0, rxThresh} + 1'b1;
  assign txEmptyLvl = (txCount <= {1'b0, txThresh});
  assign rxFullLvl  = (rxCount >= rxTrip);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txOverflow  <= 1'b0;
      rxOverrun   <= 1'b0;
      rxUnderflow <= 1'b0;
    end else begin
      txOverflow  <= enable && busWrEn  && txFull;
      rxOverrun   <= enable && rxPushEn && rxFull;
      rxUnderflow <= enable && busRdEn  && rxEmpty;
    end
  end

  a_r6_overflow_at_full: assert property (@(posedge clk) disable iff (!rstN)
    txOverflow |-> $past(txCount) == FULL_CNT);

  a_r7_overrun_at_full: assert property (@(posedge clk) disable iff (!rstN)
    rxOverrun |-> $past(rxCount) == FULL_CNT);

  a_r8_underflow_at_empty: assert property (@(posedge clk) disable iff (!rstN)
    rxUnderflow |-> $past(rxCount) == '0);

  a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !txOverflow && !rxOverrun && !rxUnderflow);

endmodule

// File: rtl/serial_fifo_pair.sv
module serial_fifo_pair
  import serial_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int WIDTH = 16,
  localparam int TW   = $clog2(DEPTH),
  localparam int CW   = TW + 1,
  localparam int FW   = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [FW-1:0]    frameSize,
  input  logic [TW-1:0]    txThresh,
  input  logic [TW-1:0]    rxThresh,
  input  logic             busWrEn,
  input  logic [WIDTH-1:0] busWrData,
  input  logic             txPopEn,
  output logic [WIDTH-1:0] txPopData,
  output logic             txPopValid,
  input  logic             rxPushEn,
  input  logic [WIDTH-1:0] rxPushData,
  input  logic             busRdEn,
  output logic [WIDTH-1:0] busRdData,
  output logic [CW-1:0]    txCount,
  output logic [CW-1:0]    rxCount,
  output logic             txEmptyLvl,
  output logic             rxFullLvl,
  output logic             txOverflow,
  output logic             rxOverrun,
  output logic             rxUnderflow
);

  fifoStrobe_t strb;

  serial_fifo_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (enable),
    .busWrEn     (busWrEn),
    .txPopEn     (txPopEn),
    .rxPushEn    (rxPushEn),
    .busRdEn     (busRdEn),
    .txCount     (txCount),
    .rxCount     (rxCount),
    .txThresh    (txThresh),
    .rxThresh    (rxThresh),
    .strb        (strb),
    .txPopValid  (txPopValid),
    .txEmptyLvl  (txEmptyLvl),
    .rxFullLvl   (rxFullLvl),
    .txOverflow  (txOverflow),
    .rxOverrun   (rxOverrun),
    .rxUnderflow (rxUnderflow)
  );

  serial_fifo_data #(.DEPTH(DEPTH), .WIDTH(WIDTH)) data_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .frameSize  (frameSize),
    .busWrData  (busWrData),
    .rxPushData (rxPushData),
    .txPopData  (txPopData),
    .busRdData  (busRdData),
    .txCount    (txCount),
    .rxCount    (rxCount)
  );

endmodule

// File: tb/serial_fifo_pair_tb_top.sv
module serial_fifo_pair_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rstN, enable;
  logic [3:0]  frameSize;
  logic [5:0]  txThresh, rxThresh;
  logic        busWrEn, txPopEn, rxPushEn, busRdEn;
  logic [15:0] busWrData, rxPushData, txPopData, busRdData;
  logic        txPopValid, txEmptyLvl, rxFullLvl;
  logic        txOverflow, rxOverrun, rxUnderflow;
  logic [6:0]  txCount, rxCount;

  int testCount = 0;
  int failCount = 0;
  logic [15:0] txQ [$];
  logic [15:0] rxQ [$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  serial_fifo_pair dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .frameSize(frameSize),
    .txThresh(txThresh), .rxThresh(rxThresh),
    .busWrEn(busWrEn), .busWrData(busWrData),
    .txPopEn(txPopEn), .txPopData(txPopData), .txPopValid(txPopValid),
    .rxPushEn(rxPushEn), .rxPushData(rxPushData),
    .busRdEn(busRdEn), .busRdData(busRdData),
    .txCount(txCount), .rxCount(rxCount),
    .txEmptyLvl(txEmptyLvl), .rxFullLvl(rxFullLvl),
    .txOverflow(txOverflow), .rxOverrun(rxOverrun), .rxUnderflow(rxUnderflow)
  );

  task automatic chk(input string tag, input int act, input int exp);
    testCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    busWrEn = 0; txPopEn = 0; rxPushEn = 0; busRdEn = 0;
  endtask

  function automatic int maskFor(input int fs);
    int eff;
    eff = (fs < 3) ? 3 : fs;
    return (1 << (eff + 1)) - 1;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    failCount++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    rstN = 0; enable = 1; frameSize = 4'd15; txThresh = 0; rxThresh = 0;
    busWrData = 0; rxPushData = 0;
    idle();
    tick(); tick();
    rstN = 1;
    tick();
    // R1 reset state
    chk("R1 reset txCount", int'(txCount), 0);
    chk("R1 reset rxCount", int'(rxCount), 0);
    chk("R1 reset txPopValid", int'(txPopValid), 0);
    chk("R8 empty busRdData", int'(busRdData), 0);
    chk("R1 reset pulses", int'({txOverflow, rxOverrun, rxUnderflow}), 0);

    // R2/R4 fill transmit with threshold sweep at each level
    for (int c = 0; c <= DEPTH; c++) begin
      for (int t = 0; t < DEPTH; t++) begin
        txThresh = 6'(t);
        #1;
        chk("R4 txEmptyLvl", int'(txEmptyLvl), (c <= t) ? 1 : 0);
      end
      if (c < DEPTH) begin
        busWrEn = 1; busWrData = 16'((c * 1237) ^ 16'h5A3C);
        txQ.push_back(busWrData);
        tick();
        idle();
        chk("R2 txCount grows", int'(txCount), c + 1);
        chk("R6 no overflow", int'(txOverflow), 0);
      end
    end
    // R6 write to full
    busWrEn = 1; busWrData = 16'hFFFF;
    tick(); idle();
    chk("R6 overflow pulse", int'(txOverflow), 1);
    chk("R6 count held", int'(txCount), DEPTH);
    tick();
    chk("R6 pulse one cycle", int'(txOverflow), 0);
    // R6 write plus pop at full: write still dropped
    chk("R2 head at full", int'(txPopData), int'(txQ[0]));
    busWrEn = 1; busWrData = 16'h1111; txPopEn = 1;
    tick(); idle();
    void'(txQ.pop_front());
    chk("R6 overflow with pop", int'(txOverflow), 1);
    chk("R6 count after pop", int'(txCount), DEPTH - 1);
    // R9 push and pop mid-level
    busWrEn = 1; busWrData = 16'h2468; txPopEn = 1;
    chk("R9 head before", int'(txPopData), int'(txQ[0]));
    tick(); idle();
    void'(txQ.pop_front()); txQ.push_back(16'h2468);
    chk("R9 tx count unchanged", int'(txCount), DEPTH - 1);
    // R2 drain in order
    while (txQ.size() > 0) begin
      chk("R2 txPopValid", int'(txPopValid), 1);
      chk("R2 tx order", int'(txPopData), int'(txQ[0]));
      txPopEn = 1;
      tick(); idle();
      void'(txQ.pop_front());
      chk("R2 txCount drains", int'(txCount), txQ.size());
    end
    txPopEn = 1;
    tick(); idle();
    chk("R2 empty pop ignored", int'(txCount), 0);
    chk("R2 empty valid", int'(txPopValid), 0);

    // R3/R5 fill receive with threshold sweep
    for (int c = 0; c <= DEPTH; c++) begin
      for (int t = 0; t < DEPTH; t++) begin
        rxThresh = 6'(t);
        #1;
        chk("R5 rxFullLvl", int'(rxFullLvl), (c >= t + 1) ? 1 : 0);
      end
      if (c < DEPTH) begin
        rxPushEn = 1; rxPushData = 16'((c * 3571) ^ 16'hC3A5);
        rxQ.push_back(rxPushData);
        tick(); idle();
        chk("R3 rxCount grows", int'(rxCount), c + 1);
        chk("R7 no overrun", int'(rxOverrun), 0);
      end
    end
    rxPushEn = 1; rxPushData = 16'hFFFF;
    tick(); idle();
    chk("R7 overrun pulse", int'(rxOverrun), 1);
    chk("R7 count held", int'(rxCount), DEPTH);
    tick();
    chk("R7 pulse one cycle", int'(rxOverrun), 0);
    rxPushEn = 1; rxPushData = 16'h3333; busRdEn = 1;
    chk("R3 head at full", int'(busRdData), int'(rxQ[0]));
    tick(); idle();
    void'(rxQ.pop_front());
    chk("R7 overrun with read", int'(rxOverrun), 1);
    chk("R7 count after read", int'(rxCount), DEPTH - 1);
    rxPushEn = 1; rxPushData = 16'h1357; busRdEn = 1;
    tick(); idle();
    void'(rxQ.pop_front()); rxQ.push_back(16'h1357);
    chk("R9 rx count unchanged", int'(rxCount), DEPTH - 1);
    while (rxQ.size() > 0) begin
      chk("R3 rx order", int'(busRdData), int'(rxQ[0]));
      busRdEn = 1;
      tick(); idle();
      void'(rxQ.pop_front());
      chk("R3 rxCount drains", int'(rxCount), rxQ.size());
      chk("R8 no underflow", int'(rxUnderflow), 0);
    end
    // R8 underflow
    chk("R8 empty reads zero", int'(busRdData), 0);
    busRdEn = 1;
    tick(); idle();
    chk("R8 underflow pulse", int'(rxUnderflow), 1);
    chk("R8 count stays 0", int'(rxCount), 0);
    tick();
    chk("R8 pulse one cycle", int'(rxUnderflow), 0);
    busRdEn = 1; rxPushEn = 1; rxPushData = 16'h0ABC;
    tick(); idle();
    chk("R8 underflow with push", int'(rxUnderflow), 1);
    chk("R8 push still stored", int'(rxCount), 1);
    chk("R8 pushed data", int'(busRdData), 16'h0ABC);
    busRdEn = 1;
    tick(); idle();

    // R10 frame masking on both sides
    for (int fs = 0; fs < 16; fs++) begin
      frameSize = 4'(fs);
      busWrEn = 1; busWrData = 16'hFFFF; rxPushEn = 1; rxPushData = 16'hFFFF;
      tick(); idle();
      chk("R10 tx mask", int'(txPopData), maskFor(fs));
      chk("R10 rx mask", int'(busRdData), maskFor(fs));
      txPopEn = 1; busRdEn = 1;
      tick(); idle();
    end
    frameSize = 4'd15;

    // R1 disable flush and ignored requests
    for (int i = 0; i < 5; i++) begin
      busWrEn = 1; busWrData = 16'(i); rxPushEn = 1; rxPushData = 16'(i);
      tick();
    end
    idle();
    chk("R1 tx filled", int'(txCount), 5);
    enable = 0;
    tick();
    chk("R1 tx flushed", int'(txCount), 0);
    chk("R1 rx flushed", int'(rxCount), 0);
    busWrEn = 1; rxPushEn = 1; busRdEn = 1;
    tick(); idle();
    chk("R1 disabled tx ignored", int'(txCount), 0);
    chk("R1 disabled rx ignored", int'(rxCount), 0);
    chk("R1 disabled no underflow", int'(rxUnderflow), 0);
    enable = 1;
    tick();
    chk("R1 re-enabled empty", int'(txCount + rxCount), 0);

    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule